// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Generator

This block emits one high pulse of programmable length each time its selected trigger source makes a 0-to-1 transition. When a trigger edge is accepted, a counter starts from zero and the output stays high while it counts. When the counter reaches the active width value, the output goes low and the counter stops until the next accepted edge. The trigger source is either a software-controlled bit or an external line. The external line is synchronized first, and only transitions are acted on, never levels.

Software sets the pulse length by writing a shadow register. The active width register takes the shadow value only at the moment a new edge is accepted while the block is idle, so a pulse that is already running never changes length. A separate tally counts every edge seen on the selected source, including edges that arrive during a running pulse. On every third such edge it raises a one-cycle interrupt strobe, which software can use to step the width between pulses. With a 100 MHz clock the intended widths are 20 to 80 cycles in steps of 5. The register accepts any 8-bit value.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A 0-to-1 transition of the selected source starts a pulse. Counting in clock edges that sample the input, `pulse_o` rises 2 edges after `sw_trig_i` rises and 3 edges after `ext_trig_i` rises. A source held high starts no further pulse.
- R2: A started pulse keeps `pulse_o` high for exactly M consecutive cycles, where M is the active width. The output then returns low and stays low until a new edge is accepted.
- R3: `trig_mode_i` = 0 selects `sw_trig_i` and `trig_mode_i` = 1 selects `ext_trig_i`. Transitions on the source that is not selected produce no pulse and are not counted by the tally.
- R4: When an edge is accepted while idle, the active width is loaded from the shadow register, and that pulse uses the new value. Writing through `shadow_we_i`/`shadow_wdata_i` changes only the shadow register.
- R5: A shadow write made during a running pulse does not change that pulse's length. It takes effect on the next accepted edge.
- R6: An edge that arrives while a pulse is running is ignored for pulse generation but is still counted toward the interrupt tally.
- R7: `irq_o` is a one-cycle strobe on every third counted edge. It is high in the cycle where an accepted pulse would rise, and the tally restarts from zero after each strobe.
- R8: A synchronous reset drives `pulse_o` and `irq_o` low, clears the tally and the pulse counter, and sets both width registers to 20.
- R9: An active width of zero produces no pulse. The edge still counts toward the interrupt tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_mode_i | input | 1 | Trigger source select: 0 software bit, 1 external line |
| sw_trig_i | input | 1 | Software trigger bit |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| shadow_we_i | input | 1 | Shadow width write enable |
| shadow_wdata_i | input | 8 | Shadow width value in cycles |
| pulse_o | output | 1 | One-shot pulse output |
| irq_o | output | 1 | One-cycle interrupt strobe every third trigger |

## Verification
The pulse function is driven with short software strobes, with a software bit held high well past the pulse end, and with external-line strobes. These separate edge response from level response and show the two trigger latencies. A sweep of widths from 20 to 80 in steps of 5 checks the count length. Retriggers during a pulse and shadow writes during a pulse show that the running width stays fixed while the tally still advances. Toggling the source that is not selected, writing a zero width, and applying a mid-run reset confirm, in turn, that the mode gates both pulse and tally, that zero suppresses the pulse, and that reset restores the width of 20 and an empty tally.

// File: rtl/osp_pkg.sv
package osp_pkg;
  typedef enum logic {
    TRIG_SW  = 1'b0,
    TRIG_EXT = 1'b1
  } trig_src_e;
endpackage

// File: rtl/osp_trig_front.sv
module osp_trig_front
  import osp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  trig_src_e mode_i,
  input  logic      sw_i,
  input  logic      ext_i,
  output logic      edge_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   ext_prev;
  logic                   sw_cur;
  logic                   sw_prev;
  logic                   ext_rise;
  logic                   sw_rise;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) ext_sync <= '0;
        else     ext_sync <= ext_i;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) ext_sync <= '0;
        else     ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b0;
      sw_cur   <= 1'b0;
      sw_prev  <= 1'b0;
    end else begin
      ext_prev <= ext_sync[LAST];
      sw_cur   <= sw_i;
      sw_prev  <= sw_cur;
    end
  end

  assign ext_rise = ext_sync[LAST] & ~ext_prev;
  assign sw_rise  = sw_cur & ~sw_prev;

  always_comb begin
    if (mode_i == TRIG_EXT) edge_o = ext_rise;
    else                    edge_o = sw_rise;
  end
endmodule

// File: rtl/osp_width_regs.sv
module osp_width_regs #(
  parameter int WIDTH_W     = 8,
  parameter int RESET_WIDTH = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [WIDTH_W-1:0] wr_data_i,
  input  logic               load_i,
  output logic [WIDTH_W-1:0] shadow_o,
  output logic [WIDTH_W-1:0] active_o
);
  localparam logic [WIDTH_W-1:0] INIT_W = WIDTH_W'(RESET_WIDTH);

  logic [WIDTH_W-1:0] shadow_q;
  logic [WIDTH_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= INIT_W;
      active_q <= INIT_W;
    end else begin
      if (wr_en_i) shadow_q <= wr_data_i;
      if (load_i)  active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/osp_pulse_core.sv
module osp_pulse_core #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               edge_i,
  input  logic [WIDTH_W-1:0] shadow_i,
  input  logic [WIDTH_W-1:0] active_i,
  output logic               load_o,
  output logic               pulse_o
);
  logic [WIDTH_W-1:0] cnt_q;
  logic               pulse_q;
  logic               accept;
  logic               start;
  logic               done;

  assign accept = edge_i & ~pulse_q;
  assign start  = accept & (shadow_i != '0);
  assign done   = pulse_q & (cnt_q == active_i);
  assign load_o = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= WIDTH_W'(1);
      pulse_q <= 1'b1;
    end else if (done) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      cnt_q   <= cnt_q + WIDTH_W'(1);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/osp_evt_tally.sv
module osp_evt_tally #(
  parameter int IRQ_EVERY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic irq_o
);
  localparam int TW = (IRQ_EVERY > 2) ? $clog2(IRQ_EVERY) : 1;
  localparam logic [TW-1:0] TOP = TW'(IRQ_EVERY - 1);

  logic [TW-1:0] tally_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (edge_i) begin
        if (tally_q == TOP) begin
          tally_q <= '0;
          irq_q   <= 1'b1;
        end else begin
          tally_q <= tally_q + TW'(1);
        end
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import osp_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int RESET_WIDTH = 20,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_EVERY   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_mode_i,
  input  logic               sw_trig_i,
  input  logic               ext_trig_i,
  input  logic               shadow_we_i,
  input  logic [WIDTH_W-1:0] shadow_wdata_i,
  output logic               pulse_o,
  output logic               irq_o
);
  logic               trig_edge;
  logic               load_act;
  logic [WIDTH_W-1:0] shd_width;
  logic [WIDTH_W-1:0] act_width;

  osp_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk    (clk),
    .rst    (rst),
    .mode_i (trig_src_e'(trig_mode_i)),
    .sw_i   (sw_trig_i),
    .ext_i  (ext_trig_i),
    .edge_o (trig_edge)
  );

  osp_width_regs #(.WIDTH_W(WIDTH_W), .RESET_WIDTH(RESET_WIDTH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (shadow_we_i),
    .wr_data_i (shadow_wdata_i),
    .load_i    (load_act),
    .shadow_o  (shd_width),
    .active_o  (act_width)
  );

  osp_pulse_core #(.WIDTH_W(WIDTH_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .edge_i   (trig_edge),
    .shadow_i (shd_width),
    .active_i (act_width),
    .load_o   (load_act),
    .pulse_o  (pulse_o)
  );

  osp_evt_tally #(.IRQ_EVERY(IRQ_EVERY)) u_tally (
    .clk    (clk),
    .rst    (rst),
    .edge_i (trig_edge),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/osp_checker.sv
module osp_checker #(
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pulse_o,
  input logic               irq_o,
  input logic               trig_edge,
  input logic [WIDTH_W-1:0] act_width
);
  logic [WIDTH_W:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)          hi_run <= '0;
    else if (pulse_o) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  a_r1_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(trig_edge));

  a_r2_width_match: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> (hi_run == {1'b0, act_width}));

  a_r5_active_stable: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && $past(pulse_o)) |-> $stable(act_width));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pulse_o && !irq_o));

  a_r9_zero_no_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> (act_width != '0));
endmodule

bind oneshot_pulse_gen osp_checker #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pulse_o   (pulse_o),
  .irq_o     (irq_o),
  .trig_edge (trig_edge),
  .act_width (act_width)
);

// File: tb/oneshot_pulse_gen_tb.sv
module oneshot_pulse_gen_tb;
  typedef struct {
    int start;
    int width;
  } pulse_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_mode = 1'b0;
  logic       sw_trig = 1'b0;
  logic       ext_trig = 1'b0;
  logic       shd_we = 1'b0;
  logic [7:0] shd_data = 8'd0;
  logic       pulse_o;
  logic       irq_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int pulses_seen = 0;
  int irqs_seen = 0;

  pulse_item_t exp_pulse_q[$];
  int          exp_irq_q[$];

  int m_shadow = 20;
  int m_tally = 0;
  int m_busy_end = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oneshot_pulse_gen u_dut (
    .clk            (clk),
    .rst            (rst),
    .trig_mode_i    (trig_mode),
    .sw_trig_i      (sw_trig),
    .ext_trig_i     (ext_trig),
    .shadow_we_i    (shd_we),
    .shadow_wdata_i (shd_data),
    .pulse_o        (pulse_o),
    .irq_o          (irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: raises a source for 'hold' cycles and predicts the outcome.
  task automatic fire(input logic src, input int hold);
    int p;
    @(negedge clk);
    p = cyc + (src ? 3 : 2);
    if (src == trig_mode) begin
      m_tally++;
      if (m_tally == 3) begin
        exp_irq_q.push_back(p);
        m_tally = 0;
      end
      if (p >= m_busy_end) begin
        if (m_shadow != 0) begin
          exp_pulse_q.push_back('{start: p, width: m_shadow});
          m_busy_end = p + m_shadow + 1;
        end
      end
    end
    if (src) ext_trig = 1'b1;
    else     sw_trig = 1'b1;
    repeat (hold) @(negedge clk);
    ext_trig = 1'b0;
    sw_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_shadow(input int val);
    @(negedge clk);
    shd_we = 1'b1;
    shd_data = 8'(val);
    @(negedge clk);
    shd_we = 1'b0;
    m_shadow = val;
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  // Monitor: pops expected items as results appear.
  logic prev_pulse = 1'b0;
  int   rise_cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse_o && !prev_pulse) rise_cyc = cyc;
      if (!pulse_o && prev_pulse) begin
        pulses_seen++;
        if (exp_pulse_q.size() == 0) begin
          check(1'b0, "R1/R6 unexpected pulse", rise_cyc, -1);
        end else begin
          pulse_item_t it;
          it = exp_pulse_q.pop_front();
          check(rise_cyc == it.start, "R1 pulse start", rise_cyc, it.start);
          check(cyc - rise_cyc == it.width, "R2/R4/R5 pulse width", cyc - rise_cyc, it.width);
        end
      end
      if (irq_o) begin
        irqs_seen++;
        if (exp_irq_q.size() == 0) begin
          check(1'b0, "R7 unexpected irq", cyc, -1);
        end else begin
          int e;
          e = exp_irq_q.pop_front();
          check(cyc == e, "R7 irq cycle", cyc, e);
        end
      end
    end
    prev_pulse = pulse_o;
  end

  task automatic finish_run();
    check(exp_pulse_q.size() == 0, "R2 missing pulses", exp_pulse_q.size(), 0);
    check(exp_irq_q.size() == 0, "R7 missing irqs", exp_irq_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ps;
    int is;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(pulse_o == 1'b0, "R8 pulse after reset", int'(pulse_o), 0);
    check(irq_o == 1'b0, "R8 irq after reset", int'(irq_o), 0);

    // R8/R1: default width, short software strobe
    fire(1'b0, 1);
    settle();
    // R1: level held far past pulse end -> single pulse
    fire(1'b0, 60);
    settle();
    // R4: new width via shadow
    write_shadow(40);
    fire(1'b0, 2);
    settle();
    // R5/R6: retrigger and shadow write during a running pulse
    fire(1'b0, 2);
    write_shadow(25);
    fire(1'b0, 2);
    settle();
    fire(1'b0, 2);
    settle();
    // R2: width sweep 20..80 step 5
    for (int w = 20; w <= 80; w += 5) begin
      write_shadow(w);
      fire(1'b0, 1);
      settle();
    end
    // R9: zero width gives no pulse but still counts
    write_shadow(0);
    ps = pulses_seen;
    fire(1'b0, 1);
    settle();
    check(pulses_seen == ps, "R9 zero width pulse count", pulses_seen, ps);
    // R3: external mode, software bit ignored
    write_shadow(30);
    @(negedge clk);
    trig_mode = 1'b1;
    ps = pulses_seen;
    is = irqs_seen;
    for (int k = 0; k < 4; k++) begin
      fire(1'b0, 2);
    end
    settle();
    check(pulses_seen == ps, "R3 ignored source pulses", pulses_seen, ps);
    check(irqs_seen == is, "R3 ignored source irqs", irqs_seen, is);
    for (int k = 0; k < 4; k++) begin
      fire(1'b1, 2);
      settle();
    end
    fire(1'b1, 50);
    settle();
    // R3: back to software, external ignored
    @(negedge clk);
    trig_mode = 1'b0;
    ps = pulses_seen;
    fire(1'b1, 2);
    fire(1'b1, 2);
    settle();
    check(pulses_seen == ps, "R3 ext ignored in sw mode", pulses_seen, ps);
    // R8: mid-run reset restores width 20 and empty tally
    write_shadow(60);
    fire(1'b0, 1);
    settle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_shadow = 20;
    m_tally = 0;
    m_busy_end = 0;
    @(negedge clk);
    check(pulse_o == 1'b0 && irq_o == 1'b0, "R8 outputs after reset", int'(pulse_o), 0);
    for (int k = 0; k < 3; k++) begin
      fire(1'b0, 1);
      settle();
    end
    finish_run();
  end
endmodule